// File: doc/BRIEF.md
# Arbitrary-Order One-Hot Sequence Counter

This block is a small counter whose output visits a fixed, freely chosen list of 3-bit values rather than counting upward. A three-stage serial shift register circulates a single logic 1. Stage 1 is loaded with the NOR of all three stages, and every other stage copies its left neighbour. The register therefore passes through four states: all clear, stage 1, stage 2, stage 3, and then all clear again.

Each stage is tied to one input of an 8-to-3 priority encoder. The encoder works with active-low signals: the stage bits are inverted on the way in, and the encoder code is inverted on the way out. The code that results is the count. Three parameters choose which encoder input each stage drives. To get a different sequence you change only these parameters; no next-state logic needs to be rewritten. With the default mapping of 1, 3 and 6, the count runs 0, 1, 3, 6 and repeats.

Top module: `ohseq_counter`

## Requirements
- R1: Reset is synchronous and active-high. A clock edge with `rst` high clears all stages and sets `count` to 0, whatever the value of `en`.
- R2: A clock edge with `rst` low and `en` low leaves `stages` and `count` unchanged.
- R3: On an enabled edge, `stages[0]` (stage 1) takes the NOR of all three stages, and `stages[k]` takes `stages[k-1]`. Starting from reset, the vector therefore runs 000, 001, 010, 100, 000, a period of four enabled clocks.
- R4: After reset, at most one bit of `stages` is ever set.
- R5: `count` is the index of the highest encoder input that is active. Encoder input TAP1 is driven by `stages[0]`, input TAP2 by `stages[1]` and input TAP3 by `stages[2]`. When no stage is set, `count` is 0.
- R6: With the default parameters (1, 3, 6), successive enabled clocks after reset produce `count` values 0, 1, 3, 6, 0, and so on. With TAP1=5, TAP2=2 and TAP3=7, they produce 0, 5, 2, 7, 0.
- R7: TAP1, TAP2 and TAP3 must each lie in the range 1 to 7 and must all be different; an elaboration-time check rejects any other mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable |
| count | output | 3 | Current sequence value |
| stages | output | 3 | Raw shift-register stages, bit 0 is stage 1 |

## Verification
Reset and advance can occur on the same edge. The bench provokes this by raising `rst` while `en` is high, at every phase of the cycle, including the phase where stage 3 is about to wrap. It passes when the stages come back cleared rather than shifted, and when the count restarts at 0. Random streams of `en` and occasional `rst` drive a default instance and an instance with the remapped parameters side by side. Each instance is compared every cycle against a phase model kept in the bench.

// File: rtl/ohseq_counter.sv
module ohseq_counter #(
  parameter int unsigned TAP1 = 1,
  parameter int unsigned TAP2 = 3,
  parameter int unsigned TAP3 = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] count,
  output logic [2:0] stages
);

  localparam logic [2:0] IDX1 = TAP1[2:0];
  localparam logic [2:0] IDX2 = TAP2[2:0];
  localparam logic [2:0] IDX3 = TAP3[2:0];

  logic [2:0] q;
  logic       inject;
  logic [7:0] enc_in_n;
  logic [2:0] enc_out_n;

  assign inject = ~|q;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[1:0], inject};
  end

  always_comb begin
    enc_in_n       = '1;
    enc_in_n[IDX1] = ~q[0];
    enc_in_n[IDX2] = ~q[1];
    enc_in_n[IDX3] = ~q[2];
  end

  always_comb begin
    enc_out_n = '1;
    for (int i = 0; i < 8; i++)
      if (!enc_in_n[i]) enc_out_n = ~3'(i);
  end

  assign count  = ~enc_out_n;
  assign stages = q;

  initial begin
    a_r7_map_legal: assert (TAP1 >= 1 && TAP1 <= 7 && TAP2 >= 1 && TAP2 <= 7 &&
                            TAP3 >= 1 && TAP3 <= 7 && TAP1 != TAP2 &&
                            TAP1 != TAP3 && TAP2 != TAP3)
      else $error("tap mapping illegal");
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (stages == 3'b000 && count == 3'd0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(stages) && $stable(count)));

  a_r3_inject: assert property (@(posedge clk) disable iff (rst)
    (en && stages == 3'b000) |=> stages == 3'b001);

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && stages[2]) |=> stages == 3'b000);

  a_r4_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stages));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (stages == 3'b000) == (count == 3'd0));

endmodule

// File: tb/ohseq_counter_tb_top.sv
`timescale 1ns/1ps
module ohseq_counter_tb_top;

  logic clk = 1'b0;
  logic rst, en;
  logic [2:0] cnt_a, stg_a, cnt_b, stg_b;
  int n_chk = 0, n_bad = 0;
  int ph = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ohseq_counter dut_i (.clk(clk), .rst(rst), .en(en), .count(cnt_a), .stages(stg_a));
  ohseq_counter #(.TAP1(5), .TAP2(2), .TAP3(7)) dut2_i
    (.clk(clk), .rst(rst), .en(en), .count(cnt_b), .stages(stg_b));

  function automatic logic [2:0] exp_stages(int p);
    return (p == 0) ? 3'b000 : 3'(1 << (p - 1));
  endfunction

  function automatic logic [2:0] exp_count(int p, int t1, int t2, int t3);
    case (p)
      1: return 3'(t1);
      2: return 3'(t2);
      3: return 3'(t3);
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3 stages A"}, stg_a, exp_stages(ph));
    chk({tag, " R5 count A"}, cnt_a, exp_count(ph, 1, 3, 6));
    chk({tag, " R3 stages B"}, stg_b, exp_stages(ph));
    chk({tag, " R5 count B"}, cnt_b, exp_count(ph, 5, 2, 7));
    n_chk++;
    if ($countones(stg_a) > 1) begin
      n_bad++;
      $display("FAIL R4 actual=%b expected=onehot0", stg_a);
    end
  endtask

  task automatic step(bit r, bit e, string tag);
    rst = r; en = e;
    @(posedge clk);
    if (r) ph = 0;
    else if (e) ph = (ph + 1) % 4;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    step(1, 0, "R1 reset");
    chk("R1 count zero", cnt_a, 3'd0);
    begin : seq_default
      logic [2:0] want [4] = '{3'd0, 3'd1, 3'd3, 3'd6};
      logic [2:0] want2 [4] = '{3'd0, 3'd5, 3'd2, 3'd7};
      for (int i = 1; i <= 12; i++) begin
        step(0, 1, "R6 run");
        chk("R6 default seq", cnt_a, want[i % 4]);
        chk("R6 remap seq", cnt_b, want2[i % 4]);
      end
    end
    step(0, 1, "R3 advance");
    for (int i = 0; i < 3; i++) step(0, 0, "R2 hold");
    chk("R2 held count", cnt_a, 3'd1);
    for (int p = 0; p < 4; p++) begin
      step(1, 1, "R1 reset");
      for (int k = 0; k < p; k++) step(0, 1, "R3 climb");
      step(1, 1, "R1 reset beats enable");
      chk("R1 stages cleared", stg_a, 3'b000);
    end
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      bit r = ($urandom % 23) == 0;
      bit e = ($urandom % 4) != 0;
      step(r, e, "rand R2 R3 R5");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule